// File: doc/BRIEF.md
# Reference-Tracking Output Voltage Window Monitor

This block watches the output of a multi-phase core regulator. It turns a 5-bit voltage-identification code into a reference in millivolts. It then compares a digitized output-voltage sample, one LSB per millivolt, against fixed percentages of that reference. From these comparisons it produces four flags:

- a power-good flag;
- a non-latched undervoltage flag with hysteresis;
- a live overvoltage flag with falling hysteresis;
- a latched overvoltage flag that only the power-on reset clears.

The all-ones code does not select a voltage. It means that the output is switched off, and the block reports it on a separate flag.

Power-good also depends on two control inputs. The soft-start sequencer asserts `ss_done` when start-up has finished. The overcurrent logic asserts `oc_restart` while a hiccup restart is in progress. Every output is registered and follows the inputs with one clock of latency. The ADC, the sequencer and the current-limit logic sit outside this block.

Top module: `vid_window_mon`

## Requirements
- R1: While `rst` is high at a clock edge, all five outputs are 0 after that edge.
- R2: For codes 0 to 30 the reference is 1700 − 25·code mV, so code 0 gives 1700 mV and code 30 gives 950 mV. Every threshold below is derived from this value.
- R3: Code 31 (all ones) sets `vid_off`. While it is applied, `pgood`, `uv` and `ov_active` stay 0 whatever the sample, and no overvoltage can be detected.
- R4: `ov_active` sets when the sample is strictly greater than floor(ref·115/100).
- R5: Once set, `ov_active` stays set while the sample is at or above floor(ref·113/100), and clears below that value.
- R6: `ov_latched` sets in the same cycle as `ov_active`. It then stays 1, whatever the sample, until `rst`.
- R7: `uv` sets when the sample is below ceil(ref·91/100). Once set, it clears as soon as the sample reaches ceil(ref·93/100). It is never latched.
- R8: `pgood` sets when all of the following hold: `ss_done` is 1, the sample is at or above ceil(ref·97/100), and no off, undervoltage, latched-overvoltage or overcurrent-restart condition is present. Once set, it holds while the sample stays above the undervoltage limit.
- R9: `pgood` is 0 after any cycle in which `ss_done` is 0, `oc_restart` is 1, `uv` is set or `ov_latched` is set.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| vid_code | input | 5 | Voltage-identification code |
| vsample | input | SAMPLE_W (12) | Output voltage sample, 1 mV per LSB |
| ss_done | input | 1 | Soft-start has completed |
| oc_restart | input | 1 | Overcurrent hiccup restart in progress |
| pgood | output | 1 | Power good |
| uv | output | 1 | Undervoltage, with hysteresis |
| ov_latched | output | 1 | Overvoltage seen since reset |
| ov_active | output | 1 | Sample currently above the overvoltage limit |
| vid_off | output | 1 | Code selects output off |

## Verification
The bench steps the sample across each threshold one millivolt at a time, at both ends of the code range.

- If a threshold is rounded in the wrong direction, or the decode is off by one step, the flag changes one sample too early or too late.
- If the hysteresis is missing, `uv` or `ov_active` clears as soon as the sample re-enters the window, instead of waiting for the clear limit.
- If the latch is missing, `ov_latched` drops when the sample falls back.
- If the off code is decoded as a voltage, a 4 V sample raises `ov_active`.

A randomized phase then compares every output on every clock against a behavioural integer model. This catches gating mistakes in `pgood`, such as ignoring `oc_restart`.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  localparam int unsigned VID_W = 5;

  // Percentage of a reference value. When round_up is set, the result is
  // rounded up so that a "below" limit trips early; otherwise it is rounded
  // down so that an "above" limit trips early.
  function automatic int unsigned pct_of(input int unsigned rv,
                                         input int unsigned pct,
                                         input bit round_up);
    int unsigned prod;
    prod = rv * pct;
    if (round_up) return (prod + 99) / 100;
    return prod / 100;
  endfunction
endpackage

// File: rtl/vwm_ref_decode.sv
module vwm_ref_decode #(
  parameter int unsigned BASE_MV = 1700,
  parameter int unsigned STEP_MV = 25,
  parameter int unsigned REF_W   = 11
) (
  input  logic [vwm_pkg::VID_W-1:0] code,
  output logic [REF_W-1:0]          ref_mv,
  output logic                      off
);
  int unsigned dec;

  always_comb begin
    dec    = BASE_MV - STEP_MV * int'(code);
    ref_mv = REF_W'(dec);
    off    = &code;
  end
endmodule

// File: rtl/vwm_scale.sv
module vwm_scale #(
  parameter int unsigned REF_W    = 11,
  parameter int unsigned OUT_W    = 12,
  parameter int unsigned PCT      = 100,
  parameter bit          ROUND_UP = 1'b0
) (
  input  logic [REF_W-1:0] ref_mv,
  output logic [OUT_W-1:0] th
);
  always_comb th = OUT_W'(vwm_pkg::pct_of(int'(ref_mv), PCT, ROUND_UP));
endmodule

// File: rtl/vwm_hyst.sv
module vwm_hyst #(
  parameter int unsigned W     = 12,
  parameter bit          ABOVE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] value,
  input  logic [W-1:0] set_th,
  input  logic [W-1:0] clr_th,
  output logic         state_n,
  output logic         state_q
);
  logic trip, hold;

  generate
    if (ABOVE) begin : g_above
      always_comb begin
        trip = value > set_th;
        hold = value >= clr_th;
      end
    end else begin : g_below
      always_comb begin
        trip = value < set_th;
        hold = value < clr_th;
      end
    end
  endgenerate

  always_comb state_n = en && (trip || (state_q && hold));

  always_ff @(posedge clk) begin
    if (rst) state_q <= 1'b0;
    else     state_q <= state_n;
  end
endmodule

// File: rtl/vid_window_mon.sv
module vid_window_mon #(
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned BASE_MV    = 1700,
  parameter int unsigned STEP_MV    = 25,
  parameter int unsigned OV_PCT     = 115,
  parameter int unsigned OV_CLR_PCT = 113,
  parameter int unsigned UV_PCT     = 91,
  parameter int unsigned UV_CLR_PCT = 93,
  parameter int unsigned PG_PCT     = 97
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [vwm_pkg::VID_W-1:0] vid_code,
  input  logic [SAMPLE_W-1:0]       vsample,
  input  logic                      ss_done,
  input  logic                      oc_restart,
  output logic                      pgood,
  output logic                      uv,
  output logic                      ov_latched,
  output logic                      ov_active,
  output logic                      vid_off
);
  localparam int unsigned REF_W = $clog2(BASE_MV + 1);
  localparam int unsigned TH_W  = REF_W + 1;
  localparam int unsigned CMP_W = (SAMPLE_W > TH_W) ? SAMPLE_W : TH_W;

  logic [REF_W-1:0] ref_mv;
  logic             off;
  logic [CMP_W-1:0] samp_x, th_ov, th_ovc, th_uv, th_uvc, th_pg;
  logic             ova_n, uv_n, ovl_n, pg_n;
  logic             ovl_q, pg_q, off_q;

  vwm_ref_decode #(.BASE_MV(BASE_MV), .STEP_MV(STEP_MV), .REF_W(REF_W)) u_dec (
    .code(vid_code), .ref_mv(ref_mv), .off(off)
  );

  // Overvoltage limits round down; undervoltage and power-good limits round up.
  vwm_scale #(.REF_W(REF_W), .OUT_W(CMP_W), .PCT(OV_PCT),     .ROUND_UP(1'b0)) u_s_ov  (.ref_mv(ref_mv), .th(th_ov));
  vwm_scale #(.REF_W(REF_W), .OUT_W(CMP_W), .PCT(OV_CLR_PCT), .ROUND_UP(1'b0)) u_s_ovc (.ref_mv(ref_mv), .th(th_ovc));
  vwm_scale #(.REF_W(REF_W), .OUT_W(CMP_W), .PCT(UV_PCT),     .ROUND_UP(1'b1)) u_s_uv  (.ref_mv(ref_mv), .th(th_uv));
  vwm_scale #(.REF_W(REF_W), .OUT_W(CMP_W), .PCT(UV_CLR_PCT), .ROUND_UP(1'b1)) u_s_uvc (.ref_mv(ref_mv), .th(th_uvc));
  vwm_scale #(.REF_W(REF_W), .OUT_W(CMP_W), .PCT(PG_PCT),     .ROUND_UP(1'b1)) u_s_pg  (.ref_mv(ref_mv), .th(th_pg));

  always_comb samp_x = CMP_W'(vsample);

  vwm_hyst #(.W(CMP_W), .ABOVE(1'b1)) u_ov (
    .clk(clk), .rst(rst), .en(!off), .value(samp_x),
    .set_th(th_ov), .clr_th(th_ovc), .state_n(ova_n), .state_q(ov_active)
  );

  vwm_hyst #(.W(CMP_W), .ABOVE(1'b0)) u_uv (
    .clk(clk), .rst(rst), .en(!off), .value(samp_x),
    .set_th(th_uv), .clr_th(th_uvc), .state_n(uv_n), .state_q(uv)
  );

  always_comb begin
    ovl_n = ovl_q || ova_n;
    pg_n  = ss_done && !off && !ovl_n && !oc_restart && !uv_n &&
            (pg_q || (samp_x >= th_pg));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovl_q <= 1'b0;
      pg_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      ovl_q <= ovl_n;
      pg_q  <= pg_n;
      off_q <= off;
    end
  end

  assign ov_latched = ovl_q;
  assign pgood      = pg_q;
  assign vid_off    = off_q;
endmodule

// File: rtl/vwm_checker.sv
module vwm_checker (
  input logic clk,
  input logic rst,
  input logic ss_done,
  input logic oc_restart,
  input logic pgood,
  input logic uv,
  input logic ov_latched,
  input logic ov_active,
  input logic vid_off
);
  a_r6_latch_sticky: assert property (@(posedge clk) disable iff (rst)
    ov_latched |=> ov_latched);

  a_r6_active_latched: assert property (@(posedge clk) disable iff (rst)
    ov_active |-> ov_latched);

  a_r3_off_quiet: assert property (@(posedge clk) disable iff (rst)
    vid_off |-> (!pgood && !uv && !ov_active));

  a_r9_pgood_exclusive: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (!uv && !ov_latched));

  a_r9_ss_gate: assert property (@(posedge clk) disable iff (rst)
    !ss_done |=> !pgood);

  a_r9_oc_gate: assert property (@(posedge clk) disable iff (rst)
    oc_restart |=> !pgood);

  a_r8_rise_needs_ss: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> $past(ss_done));
endmodule

bind vid_window_mon vwm_checker u_vwm_checker (
  .clk(clk), .rst(rst), .ss_done(ss_done), .oc_restart(oc_restart),
  .pgood(pgood), .uv(uv), .ov_latched(ov_latched), .ov_active(ov_active),
  .vid_off(vid_off)
);

// File: tb/test_vid_window_mon.sv
`timescale 1ns/1ps
module test_vid_window_mon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  vid_code = 5'd0;
  logic [11:0] vsample = 12'd0;
  logic        ss_done = 1'b0;
  logic        oc_restart = 1'b0;
  logic        pgood, uv, ov_latched, ov_active, vid_off;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Expected state, updated by the behavioural model
  bit e_pg, e_uv, e_ovl, e_ova, e_off;

  always #4 clk = ~clk;

  vid_window_mon i_vid_window_mon (
    .clk(clk), .rst(rst), .vid_code(vid_code), .vsample(vsample),
    .ss_done(ss_done), .oc_restart(oc_restart), .pgood(pgood), .uv(uv),
    .ov_latched(ov_latched), .ov_active(ov_active), .vid_off(vid_off)
  );

  // Behavioural reference model in plain integer arithmetic
  always @(posedge clk) begin
    int r, s, lim_ov, lim_ovc, lim_uv, lim_uvc, lim_pg;
    bit off, ova, uvn, ovl, pg;
    if (rst) begin
      {e_pg, e_uv, e_ovl, e_ova, e_off} = '0;
    end else begin
      r       = 1700 - 25 * int'(vid_code);
      s       = int'(vsample);
      off     = (vid_code == 5'd31);
      lim_ov  = (r * 115) / 100;
      lim_ovc = (r * 113) / 100;
      lim_uv  = (r * 91 + 99) / 100;
      lim_uvc = (r * 93 + 99) / 100;
      lim_pg  = (r * 97 + 99) / 100;
      ova = !off && ((s > lim_ov) || (e_ova && s >= lim_ovc));
      uvn = !off && ((s < lim_uv) || (e_uv && s < lim_uvc));
      ovl = e_ovl || ova;
      pg  = ss_done && !off && !ovl && !oc_restart && !uvn &&
            (e_pg || s >= lim_pg);
      e_ova = ova; e_uv = uvn; e_ovl = ovl; e_pg = pg; e_off = off;
    end
  end

  // R10: cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if ({pgood, uv, ov_latched, ov_active, vid_off} !==
          {e_pg, e_uv, e_ovl, e_ova, e_off}) begin
        fails++;
        $display("FAIL R10 model compare at cycle %0d: got %b expected %b",
                 cycles, {pgood, uv, ov_latched, ov_active, vid_off},
                 {e_pg, e_uv, e_ovl, e_ova, e_off});
      end
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic drive(input int code, input int s, input bit ss, input bit oc);
    vid_code   = 5'(code);
    vsample    = 12'(s);
    ss_done    = ss;
    oc_restart = oc;
    @(negedge clk);
  endtask

  // Directed check; the field order is {pgood, uv, ov_latched, ov_active, vid_off}
  task automatic expect_out(input logic [4:0] exp_v, input string tag);
    checks++;
    if ({pgood, uv, ov_latched, ov_active, vid_off} !== exp_v) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag,
               {pgood, uv, ov_latched, ov_active, vid_off}, exp_v);
    end
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    drive(0, 2000, 1, 0);
    drive(0, 2000, 1, 0);
    expect_out(5'b00000, "R1 reset state");
    rst = 1'b0;

    // Reference 1000 mV (code 28)
    drive(28, 1000, 0, 0); expect_out(5'b00000, "R9 no pgood before soft-start");
    drive(28, 969, 1, 0);  expect_out(5'b00000, "R8 below 97% limit 970");
    drive(28, 970, 1, 0);  expect_out(5'b10000, "R8 R2 pgood at 970");
    drive(28, 910, 1, 0);  expect_out(5'b10000, "R8 pgood holds at uv limit 910");
    drive(28, 909, 1, 0);  expect_out(5'b01000, "R7 uv below 910");
    drive(28, 929, 1, 0);  expect_out(5'b01000, "R7 uv hysteresis at 929");
    drive(28, 930, 1, 0);  expect_out(5'b00000, "R7 uv clears at 930, not latched");
    drive(28, 1000, 1, 0); expect_out(5'b10000, "R8 pgood back");
    drive(28, 1000, 1, 1); expect_out(5'b00000, "R9 overcurrent restart drops pgood");
    drive(28, 1000, 1, 0); expect_out(5'b10000, "R9 pgood after restart ends");
    drive(28, 1000, 0, 0); expect_out(5'b00000, "R9 soft-start low drops pgood");

    // Low end of the decode: reference 950 mV (code 30)
    drive(30, 921, 1, 0);  expect_out(5'b00000, "R2 code 30 below 922");
    drive(30, 922, 1, 0);  expect_out(5'b10000, "R2 code 30 pgood at 922");
    drive(30, 1092, 1, 0); expect_out(5'b10000, "R4 code 30 at ov limit 1092");

    // Off code
    drive(31, 4000, 1, 0); expect_out(5'b00001, "R3 off code ignores 4000 mV");
    drive(31, 0, 1, 0);    expect_out(5'b00001, "R3 off code ignores 0 mV");

    // Reference 1700 mV (code 0)
    drive(0, 1955, 1, 0);  expect_out(5'b10000, "R4 at ov limit 1955 no trip");
    drive(0, 1956, 1, 0);  expect_out(5'b00110, "R4 R6 trip above 1955");
    drive(0, 1921, 1, 0);  expect_out(5'b00110, "R5 ov hysteresis at 1921");
    drive(0, 1920, 1, 0);  expect_out(5'b00100, "R5 ov_active clears below 1921");
    drive(0, 1700, 1, 0);  expect_out(5'b00100, "R6 R9 latch holds, pgood low");
    drive(31, 1700, 1, 0); expect_out(5'b00101, "R6 latch survives off code");
    rst = 1'b1;
    drive(0, 1700, 1, 0);  expect_out(5'b00000, "R6 R1 only reset clears latch");
    rst = 1'b0;

    // Randomized phase, checked by the per-cycle model compare
    for (int i = 0; i < 2000; i++) begin
      int code, r;
      code = (i % 40 == 0) ? 31 : int'($urandom_range(0, 30));
      r = 1700 - 25 * code;
      for (int k = 0; k < 8; k++) begin
        drive(code, (r * int'($urandom_range(85, 120))) / 100,
              ($urandom_range(0, 9) != 0), ($urandom_range(0, 19) == 0));
      end
      if (i % 300 == 299) begin
        rst = 1'b1;
        drive(0, 0, 0, 0);
        rst = 1'b0;
      end
    end
    finish_up();
  end
endmodule